// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a floating-point coprocessor. The word carries eight condition codes, a six-bit cause field, a five-bit trap-enable field and a five-bit sticky flags field. Software loads the word as a whole. Compare instructions set or clear one indexed condition code. Each arithmetic operation reports its exception bits, which replace the cause field and accumulate into the flags field.

The block has three read outputs. The first is the full register. The second is an 8-bit packed condition vector for branch logic. The third is a trap request, raised when a reported exception is enabled or when an operation is unimplemented. All updates are registered, so a result shows on the outputs one cycle after the clock edge that captures it.

Top module: `fp_ctrl_stat`

## Requirements
- R1: While reset is asserted and after it is released, all register bits are 0, the packed condition vector is 0 and the trap request is 0.
- R2: A software write replaces the full 32-bit word, and the new value shows on `csr_o` after the next rising edge. A software write overrides any condition-code or exception update presented in the same cycle.
- R3: A condition-code update with index 0 writes register bit 23. A condition-code update with index n, for n from 1 to 7, writes register bit 24+n. No other bit changes.
- R4: `cc_vec_o` bit 0 equals register bit 23, and `cc_vec_o` bits 7:1 equal register bits 31:25.
- R5: An exception report replaces the cause field (bits 17:12) with `exc_bits_i`. The exception bit encoding is: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid, bit 5 unimplemented.
- R6: An exception report ORs `exc_bits_i[4:0]` into the flags field (bits 6:2). A flag that is set stays set until a software write.
- R7: `trap_o` is 1 exactly when cause bit 5 is set, or when any cause bit k (k from 0 to 4) and enable bit k (register bit 7+k) are both set.
- R8: Bit 24, bits 22:18, bits 1:0 and the enable field (bits 11:7) change only through a software write.
- R9: A condition-code update and an exception report in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| cc_we_i | input | 1 | Condition-code update strobe |
| cc_idx_i | input | 3 | Condition-code index |
| cc_val_i | input | 1 | Condition-code value |
| exc_valid_i | input | 1 | Exception report strobe |
| exc_bits_i | input | 6 | Exception bits reported by the operation |
| csr_o | output | 32 | Full register word |
| cc_vec_o | output | 8 | Packed condition codes |
| trap_o | output | 1 | Trap request |

## Verification
The assertions treat the three update strobes as free and independent inputs. They assume only that strobes and data are stable around the rising edge, so any mix of strobes in one cycle is legal. The stimulus changes inputs on the falling edge. It covers every condition index with both values, all 64 exception-bit patterns in sequence, and every pairing of cause and enable values. It also drives same-cycle collisions between software writes and datapath updates, and between the two datapath ports.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int W         = 32;
  localparam int NCC       = 8;
  localparam int IDX_W     = $clog2(NCC);
  localparam int CC0_POS   = 23;
  localparam int CCN_BASE  = 24;
  localparam int CAUSE_LO  = 12;
  localparam int CAUSE_W   = 6;
  localparam int EN_LO     = 7;
  localparam int EN_W      = 5;
  localparam int FLAG_LO   = 2;
  localparam int FLAG_W    = 5;
  localparam int UNIMP_BIT = CAUSE_W - 1;
endpackage

// File: rtl/fcs_cc_unit.sv
module fcs_cc_unit
  import fcs_pkg::*;
(
  input  logic [NCC-1:0]   cc_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             val_i,
  output logic [NCC-1:0]   cc_o
);
  for (genvar g = 0; g < NCC; g++) begin : g_cc
    assign cc_o[g] = (we_i && (idx_i == IDX_W'(g))) ? val_i : cc_i[g];
  end
endmodule

// File: rtl/fcs_exc_unit.sv
module fcs_exc_unit
  import fcs_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [EN_W-1:0]    en_i,
  input  logic               valid_i,
  input  logic [CAUSE_W-1:0] bits_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               trap_o
);
  always_comb begin
    cause_o = valid_i ? bits_i : cause_i;
    flags_o = valid_i ? (flags_i | bits_i[FLAG_W-1:0]) : flags_i;
  end

  // unimplemented has no enable bit: always traps
  assign trap_o = (|(cause_i[EN_W-1:0] & en_i)) | cause_i[UNIMP_BIT];
endmodule

// File: rtl/fp_ctrl_stat.sv
module fp_ctrl_stat
  import fcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [W-1:0]     sw_wdata_i,
  input  logic             cc_we_i,
  input  logic [IDX_W-1:0] cc_idx_i,
  input  logic             cc_val_i,
  input  logic             exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_bits_i,
  output logic [W-1:0]     csr_o,
  output logic [NCC-1:0]   cc_vec_o,
  output logic             trap_o
);
  logic [W-1:0]       csr_q, csr_d;
  logic [NCC-1:0]     cc_cur, cc_nxt;
  logic [CAUSE_W-1:0] cause_nxt;
  logic [FLAG_W-1:0]  flags_nxt;

  for (genvar g = 0; g < NCC; g++) begin : g_pack
    if (g == 0) begin : g_c0
      assign cc_cur[g] = csr_q[CC0_POS];
    end else begin : g_cn
      assign cc_cur[g] = csr_q[CCN_BASE + g];
    end
  end

  fcs_cc_unit u_cc (
    .cc_i  (cc_cur),
    .we_i  (cc_we_i),
    .idx_i (cc_idx_i),
    .val_i (cc_val_i),
    .cc_o  (cc_nxt)
  );

  fcs_exc_unit u_exc (
    .cause_i (csr_q[CAUSE_LO +: CAUSE_W]),
    .flags_i (csr_q[FLAG_LO +: FLAG_W]),
    .en_i    (csr_q[EN_LO +: EN_W]),
    .valid_i (exc_valid_i),
    .bits_i  (exc_bits_i),
    .cause_o (cause_nxt),
    .flags_o (flags_nxt),
    .trap_o  (trap_o)
  );

  always_comb begin
    csr_d = csr_q;
    csr_d[CC0_POS] = cc_nxt[0];
    for (int k = 1; k < NCC; k++) csr_d[CCN_BASE + k] = cc_nxt[k];
    csr_d[CAUSE_LO +: CAUSE_W] = cause_nxt;
    csr_d[FLAG_LO +: FLAG_W]   = flags_nxt;
    if (sw_we_i) csr_d = sw_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '0;
    else         csr_q <= csr_d;
  end

  assign csr_o    = csr_q;
  assign cc_vec_o = cc_cur;

  assert_sw_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> csr_o == $past(sw_wdata_i));
  assert_cc_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_we_i && cc_we_i) |=> cc_vec_o[$past(cc_idx_i)] == $past(cc_val_i));
  assert_pack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_vec_o == {csr_o[W-1:CCN_BASE+1], csr_o[CC0_POS]});
  assert_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_we_i && exc_valid_i) |=> csr_o[CAUSE_LO +: CAUSE_W] == $past(exc_bits_i));
  assert_flags_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_we_i |=> (csr_o[FLAG_LO +: FLAG_W] & $past(csr_o[FLAG_LO +: FLAG_W]))
                 == $past(csr_o[FLAG_LO +: FLAG_W]));
  assert_unimp_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[CAUSE_LO + UNIMP_BIT] |-> trap_o);
  assert_plain_bits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_we_i |=> $stable({csr_o[CCN_BASE], csr_o[22:18], csr_o[EN_LO +: EN_W], csr_o[1:0]}));
endmodule

// File: tb/fp_ctrl_stat_test.sv
module fp_ctrl_stat_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sw_we = 0;
  logic [31:0] sw_wdata = '0;
  logic        cc_we = 0;
  logic [2:0]  cc_idx = '0;
  logic        cc_val = 0;
  logic        exc_valid = 0;
  logic [5:0]  exc_bits = '0;
  logic [31:0] csr;
  logic [7:0]  cc_vec;
  logic        trap;

  int errors = 0;
  int checks = 0;
  logic [31:0] model = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_ctrl_stat uut (
    .clk_i(clk), .rst_ni(rst_n),
    .sw_we_i(sw_we), .sw_wdata_i(sw_wdata),
    .cc_we_i(cc_we), .cc_idx_i(cc_idx), .cc_val_i(cc_val),
    .exc_valid_i(exc_valid), .exc_bits_i(exc_bits),
    .csr_o(csr), .cc_vec_o(cc_vec), .trap_o(trap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pack(input logic [31:0] w);
    return {w[31:25], w[23]};
  endfunction

  function automatic logic exp_trap(input logic [31:0] w);
    return (|(w[16:12] & w[11:7])) | w[17];
  endfunction

  task automatic check_all(input string req);
    chk({req, " word"}, csr, model);
    chk({"R4 pack"}, {24'd0, cc_vec}, {24'd0, pack(model)});
    chk({"R7 trap"}, {31'd0, trap}, {31'd0, exp_trap(model)});
  endtask

  // drive at negedge, capture at posedge, check at next negedge
  task automatic step(input string req, input logic s_we, input logic [31:0] s_d,
                      input logic c_we, input logic [2:0] c_i, input logic c_v,
                      input logic e_v, input logic [5:0] e_b);
    sw_we = s_we; sw_wdata = s_d;
    cc_we = c_we; cc_idx = c_i; cc_val = c_v;
    exc_valid = e_v; exc_bits = e_b;
    if (s_we) model = s_d;
    else begin
      if (c_we) begin
        if (c_i == 0) model[23] = c_v;
        else model[24 + int'(c_i)] = c_v;
      end
      if (e_v) begin
        model[17:12] = e_b;
        model[6:2] = model[6:2] | e_b[4:0];
      end
    end
    @(negedge clk);
    sw_we = 0; cc_we = 0; exc_valid = 0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0000; bases[1] = 32'hFFFF_FFFF;
    bases[2] = 32'hA5A5_A5A5; bases[3] = 32'h017C_0F83;

    // R1 reset
    repeat (2) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after reset");

    // R2 whole-word writes, and R4 packing across patterns
    for (int i = 0; i < 32; i++) step("R2 write", 1, 32'h1 << i, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R2 write", 1, bases[i], 0, 0, 0, 0, 0);

    // R2 priority over datapath updates
    step("R2 prio", 1, 32'h1234_5678, 1, 3'd5, 1, 1, 6'h3F);
    step("R2 prio", 1, 32'h0000_0000, 1, 3'd0, 1, 1, 6'h1F);

    // R3 every index and value on several bases; R8 other bits untouched
    for (int b = 0; b < 4; b++) begin
      step("R2 base", 1, bases[b], 0, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++)
        for (int v = 0; v < 2; v++)
          step("R3 R8 cc", 0, 0, 1, 3'(i), 1'(v), 0, 0);
    end

    // R5 R6 all exception patterns, flags accumulate from zero
    step("R2 base", 1, 32'h017C_0003, 0, 0, 0, 0, 0);
    for (int e = 0; e < 64; e++) step("R5 R6 R8 exc", 0, 0, 0, 0, 0, 1, 6'(e));
    step("R6 sticky", 0, 0, 0, 0, 0, 1, 6'h00);
    step("R6 sticky idle", 0, 0, 0, 0, 0, 0, 6'h3F);
    step("R6 clear by write", 1, 32'h0, 0, 0, 0, 0, 0);
    step("R6 single flag", 0, 0, 0, 0, 0, 1, 6'h08);
    step("R5 unimp only", 0, 0, 0, 0, 0, 1, 6'h20);

    // R9 simultaneous cc and exception updates
    for (int i = 0; i < 8; i++)
      step("R9 both", 0, 0, 1, 3'(i), 1'(i[0] ^ 1'b1), 1, 6'(i * 9));

    // R7 every cause/enable pairing
    for (int c = 0; c < 64; c++)
      for (int e = 0; e < 32; e++)
        step("R7 trap sweep", 1, (32'(c) << 12) | (32'(e) << 7) | 32'h0080_0000,
             0, 0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule